// File: doc/BRIEF.md
# Pipelined Pseudo-Mersenne Residue Unit

This block takes an unsigned integer of up to `IN_W` bits, typically the full-width product leaving a large multiplier inside a number-theoretic-transform butterfly, and returns its residue modulo a prime of the shape q = 2^Y − 2^Z + 1. It needs no multiplier and no division. It relies on the congruence 2^Y ≡ 2^Z − 1 (mod q). Each fold stage splits the operand into a high part H above bit Y and a low part L below it, and rewrites the operand as L + H·2^Z − H. The stages repeat until only a small excess over Y bits is left. One conditional subtraction of q then finishes the job.

The fold count, and so the latency, follows from `IN_W`, `MOD_Y` and `MOD_Z` when the design is elaborated. Every fold and the final subtraction have a register behind them. A new operand is taken on every clock, and results leave in order with a valid flag that is delayed by the same number of stages. The parameters must satisfy MOD_Z ≥ 1, MOD_Y ≥ MOD_Z + 2 and IN_W > MOD_Y. With these limits every intermediate value stays non-negative, so no signed correction step is needed. A modulus that also meets q ≡ 1 (mod 2n) can serve a negacyclic transform of length n.

Top module: `solinas_reducer`

## Requirements
- R1: For every `IN_W`-bit input accepted with `in_valid` high, `out_data` equals that input modulo q = 2^MOD_Y − 2^MOD_Z + 1.
- R2: Whenever `out_valid` is high, `out_data` lies in [0, q−1].
- R3: Let the fold count F start at zero with w = IN_W. While w > MOD_Y+1, apply w ← max(MOD_Y, w−MOD_Y+MOD_Z)+1 and increment F, then add one more fold. Latency is F+1 register stages. A result whose input is sampled at a rising edge is on the outputs after the (F+1)-th rising edge, counting the sampling edge as the first. This gives 5 for (128, 64, 32) and 4 for (12, 6, 2).
- R4: Inputs offered on consecutive cycles each produce exactly one result, one per cycle, in arrival order, with none lost and none spurious.
- R5: While `out_valid` is low, `out_data` keeps its previous value. Any value on `in_data` with `in_valid` low produces no result and changes no output.
- R6: While `rst_n` is low (synchronous), and on the first cycle after it is released, `out_valid` is 0 and `out_data` is 0.
- R7: The boundary operands 0, q−1, q, q+1, 2q−1, 2q, 2^MOD_Y−1, 2^MOD_Y and all-ones return their exact residues. These are 0, q−1, 0, 1, q−1, 0, and so on.
- R8: The product of two residues a·b with a, b < q reduces correctly, including (q−1)² → 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_data` as an operand this cycle |
| in_data | input | IN_W | Unsigned operand to be reduced |
| out_valid | output | 1 | Marks `out_data` as a result this cycle |
| out_data | output | MOD_Y | Residue modulo q |

## Verification
The hardest condition to reach from the ports is the final subtraction boundary. The value left after the last fold must land exactly on q, or in the narrow band between q and 2q−1. Random wide operands almost never put it there. The stimulus therefore drives those values on purpose: q, q+1, 2q−1 and 2q, plus 2^MOD_Y−1 and 2^MOD_Y, whose folded forms sit near q.

A second, small instance (12-bit input, q = 61) is swept over its whole input space and over every product of two residues. That sweep reaches every fold carry pattern and every post-fold value up to the bound. The wide instance takes corner values, random operands and random residue products. Gaps with junk data and `in_valid` low cover the hold behaviour.

// File: rtl/solinas_reducer_pkg.sv
// Package: width bookkeeping for the fold pipeline.
// Assumes MOD_Z >= 1 and MOD_Y >= MOD_Z + 2, so that the widths shrink
// strictly until they reach MOD_Y + 1.
package solinas_reducer_pkg;

    // Width of the value after one fold of a w-bit operand.
    function automatic int fold_width(input int w, input int y, input int z);
        int hw;
        hw = w - y;
        return ((y > hw + z) ? y : hw + z) + 1;
    endfunction

    // Number of folds needed: shrink to y+1 bits, then one more fold to
    // bring the value below 2q.
    function automatic int fold_count(input int in_w, input int y, input int z);
        int w;
        int n;
        w = in_w;
        n = 0;
        while (w > y + 1) begin
            w = fold_width(w, y, z);
            n++;
        end
        return n + 1;
    endfunction

    // Operand width entering fold number k (k = 0 is the raw input).
    function automatic int width_at(input int k, input int in_w, input int y, input int z);
        int w;
        w = in_w;
        for (int i = 0; i < k; i++) begin
            w = fold_width(w, y, z);
        end
        return w;
    endfunction

endpackage

// File: rtl/srd_fold_step.sv
// Module: one combinational fold, x = H*2^Y + L -> L + H*2^Z - H.
// Assumes WO = max(Y, WI-Y+Z)+1, so the sum cannot wrap. Because
// H*2^Z >= H, the result is never negative.
module srd_fold_step #(
    parameter int WI = 128,
    parameter int WO = 97,
    parameter int Y  = 64,
    parameter int Z  = 32
) (
    input  logic [WI-1:0] x_i,
    output logic [WO-1:0] y_o
);
    logic [WO-1:0] lo_ext;
    logic [WO-1:0] hi_ext;

    // Split the operand and rebuild it with 2^Y replaced by 2^Z - 1.
    always_comb begin
        lo_ext = WO'(x_i[Y-1:0]);
        hi_ext = WO'(x_i[WI-1:Y]);
        y_o    = lo_ext + (hi_ext << Z) - hi_ext;
    end
endmodule

// File: rtl/srd_pipe_reg.sv
// Module: pipeline register with a valid bit. Data loads only with valid,
// so idle cycles leave the held value unchanged.
module srd_pipe_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [W-1:0] d_i,
    output logic         v_o,
    output logic [W-1:0] d_o
);
    // Advance the valid flag every cycle; capture data on valid cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            d_o <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                d_o <= d_i;
            end
        end
    end
endmodule

// File: rtl/srd_final_sub.sv
// Module: final conditional subtraction of q.
// Assumes the input is below 2q, which the last fold guarantees.
module srd_final_sub #(
    parameter int Y = 64,
    parameter int Z = 32
) (
    input  logic [Y:0]   v_i,
    output logic [Y-1:0] r_o
);
    localparam logic [Y:0] MODQ =
        ((Y+1)'(1) << Y) - ((Y+1)'(1) << Z) + (Y+1)'(1);

    logic [Y+1:0] diff;
    logic         borrow;

    // Subtract q; keep the original value if the subtraction borrows.
    always_comb begin
        diff   = {1'b0, v_i} - {1'b0, MODQ};
        borrow = diff[Y+1];
        r_o    = Y'(borrow ? v_i : diff[Y:0]);
    end
endmodule

// File: rtl/solinas_reducer.sv
// Top: reduces an IN_W-bit operand modulo q = 2^MOD_Y - 2^MOD_Z + 1.
// A chain of registered folds ends in a registered conditional subtract.
// Assumes MOD_Z >= 1, MOD_Y >= MOD_Z + 2, IN_W > MOD_Y.
// Accepts one operand per cycle. Latency is fold_count + 1 cycles.
module solinas_reducer
    import solinas_reducer_pkg::*;
#(
    parameter int IN_W  = 128,
    parameter int MOD_Y = 64,
    parameter int MOD_Z = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              out_valid,
    output logic [MOD_Y-1:0]  out_data
);
    localparam int NFOLD = fold_count(IN_W, MOD_Y, MOD_Z);

    // One registered fold per generate block; each stage reads the one before it.
    for (genvar gi = 0; gi < NFOLD; gi++) begin : g_fold
        localparam int WI = width_at(gi, IN_W, MOD_Y, MOD_Z);
        localparam int WO = width_at(gi + 1, IN_W, MOD_Y, MOD_Z);

        logic [WI-1:0] src_d;
        logic          src_v;
        logic [WO-1:0] folded;
        logic [WO-1:0] held;
        logic          held_v;

        if (gi == 0) begin : g_head
            assign src_d = in_data;
            assign src_v = in_valid;
        end else begin : g_link
            assign src_d = g_fold[gi-1].held;
            assign src_v = g_fold[gi-1].held_v;
        end

        srd_fold_step #(.WI(WI), .WO(WO), .Y(MOD_Y), .Z(MOD_Z)) u_fold (
            .x_i (src_d),
            .y_o (folded)
        );

        srd_pipe_reg #(.W(WO)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (src_v),
            .d_i   (folded),
            .v_o   (held_v),
            .d_o   (held)
        );
    end

    logic [MOD_Y-1:0] residue;

    srd_final_sub #(.Y(MOD_Y), .Z(MOD_Z)) u_final (
        .v_i (g_fold[NFOLD-1].held),
        .r_o (residue)
    );

    srd_pipe_reg #(.W(MOD_Y)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (g_fold[NFOLD-1].held_v),
        .d_i   (residue),
        .v_o   (out_valid),
        .d_o   (out_data)
    );
endmodule

// File: rtl/solinas_reducer_chk.sv
// Checker: tracks inputs over a latency-deep window and compares each
// result with the plain remainder. Also checks the result range, the valid
// timing and that outputs hold between results.
module solinas_reducer_chk
    import solinas_reducer_pkg::*;
#(
    parameter int IN_W  = 128,
    parameter int MOD_Y = 64,
    parameter int MOD_Z = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [IN_W-1:0]   in_data,
    input logic              out_valid,
    input logic [MOD_Y-1:0]  out_data
);
    localparam int LAT = fold_count(IN_W, MOD_Y, MOD_Z) + 1;
    localparam logic [MOD_Y:0] MODQ =
        ((MOD_Y+1)'(1) << MOD_Y) - ((MOD_Y+1)'(1) << MOD_Z) + (MOD_Y+1)'(1);

    logic [LAT-1:0]  v_sr;
    logic [IN_W-1:0] d_sr [LAT];
    logic [IN_W-1:0] ref_rem;

    // Delay line of input valid and data, independent of the fold datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_sr <= '0;
            for (int k = 0; k < LAT; k++) d_sr[k] <= '0;
        end else begin
            v_sr    <= {v_sr[LAT-2:0], in_valid};
            d_sr[0] <= in_data;
            for (int k = 1; k < LAT; k++) d_sr[k] <= d_sr[k-1];
        end
    end

    // Reference remainder of the delayed operand.
    always_comb ref_rem = d_sr[LAT-1] % IN_W'(MODQ);

    AST_REMAINDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == MOD_Y'(ref_rem)));                    // R1
    AST_BELOW_MODULUS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_data} < MODQ));                        // R2
    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_sr[LAT-1]);                                       // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));                               // R5
endmodule

bind solinas_reducer solinas_reducer_chk #(
    .IN_W(IN_W), .MOD_Y(MOD_Y), .MOD_Z(MOD_Z)
) u_chk (.*);

// File: tb/solinas_reducer_tb_top.sv
// Bench: a wide instance (128-bit input, q = 2^64-2^32+1) with corner,
// random and product stimulus, and a small instance (12-bit, q = 61)
// swept exhaustively. Expected residues come from the % operator.
module solinas_reducer_tb_top;
    localparam logic [127:0] BQ = (128'd1 << 64) - (128'd1 << 32) + 128'd1;
    localparam logic [63:0]  BQ64 = 64'hFFFF_FFFF_0000_0001;
    localparam int           SQ = 61;
    localparam int           LAT_B = 5;   // R3: 128->97->66->65, +1 fold, +1
    localparam int           LAT_S = 4;   // R3: 12->9->7, +1 fold, +1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    logic         in_v_b = 1'b0;
    logic [127:0] in_d_b = '0;
    logic         out_v_b;
    logic [63:0]  out_d_b;
    logic         in_v_s = 1'b0;
    logic [11:0]  in_d_s = '0;
    logic         out_v_s;
    logic [5:0]   out_d_s;

    logic [63:0] exp_b_q [$];
    int          cyc_b_q [$];
    string       tag_b_q [$];
    logic [5:0]  exp_s_q [$];
    int          cyc_s_q [$];
    string       tag_s_q [$];
    logic [63:0] last_b = '0;
    logic [5:0]  last_s = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    solinas_reducer #(.IN_W(128), .MOD_Y(64), .MOD_Z(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_v_b), .in_data(in_d_b),
        .out_valid(out_v_b), .out_data(out_d_b)
    );

    solinas_reducer #(.IN_W(12), .MOD_Y(6), .MOD_Z(2)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_v_s), .in_data(in_d_s),
        .out_valid(out_v_s), .out_data(out_d_s)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [63:0] rnd_res();
        logic [63:0] r;
        r = {$urandom, $urandom};
        return r % BQ64;
    endfunction

    // Offer one operand to the wide instance and queue its residue.
    task automatic send_b(input logic [127:0] x, input string tag);
        @(negedge clk);
        in_v_b = 1'b1;
        in_d_b = x;
        exp_b_q.push_back(64'(x % BQ));
        cyc_b_q.push_back(cyc);
        tag_b_q.push_back(tag);
    endtask

    task automatic idle_b(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_v_b = 1'b0;
            in_d_b = rnd128();   // junk that must be ignored (R5)
        end
    endtask

    task automatic send_s(input logic [11:0] x, input string tag);
        @(negedge clk);
        in_v_s = 1'b1;
        in_d_s = x;
        exp_s_q.push_back(6'(int'(x) % SQ));
        cyc_s_q.push_back(cyc);
        tag_s_q.push_back(tag);
    endtask

    // Wide monitor: in-order data, latency, and hold while idle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_v_b) begin
                if (exp_b_q.size() == 0) begin
                    check(1'b0, "R4 spurious wide result", 128'(out_d_b), 128'd0);
                end else begin
                    logic [63:0] e;
                    int c;
                    string t;
                    e = exp_b_q.pop_front();
                    c = cyc_b_q.pop_front();
                    t = tag_b_q.pop_front();
                    check(out_d_b == e, t, 128'(out_d_b), 128'(e));
                    check(out_d_b < BQ64, "R2 wide range", 128'(out_d_b), 128'(BQ64));
                    check(cyc - c == LAT_B, "R3 wide latency", 128'(cyc - c), 128'(LAT_B));
                end
                last_b = out_d_b;
            end else begin
                check(out_d_b == last_b, "R5 wide hold", 128'(out_d_b), 128'(last_b));
            end
        end
    end

    // Small monitor: same checks for the exhaustive instance.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_v_s) begin
                if (exp_s_q.size() == 0) begin
                    check(1'b0, "R4 spurious small result", 128'(out_d_s), 128'd0);
                end else begin
                    logic [5:0] e;
                    int c;
                    string t;
                    e = exp_s_q.pop_front();
                    c = cyc_s_q.pop_front();
                    t = tag_s_q.pop_front();
                    check(out_d_s == e, t, 128'(out_d_s), 128'(e));
                    check(int'(out_d_s) < SQ, "R2 small range", 128'(out_d_s), 128'(SQ));
                    check(cyc - c == LAT_S, "R3 small latency", 128'(cyc - c), 128'(LAT_S));
                end
                last_s = out_d_s;
            end else begin
                check(out_d_s == last_s, "R5 small hold", 128'(out_d_s), 128'(last_s));
            end
        end
    end

    // Watchdog: an expired run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 128'(cyc), 128'd0);
        finish_run();
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        in_d_b = rnd128();
        repeat (4) @(negedge clk);
        // R6: outputs idle and zero while reset is held, despite input activity.
        in_v_b = 1'b1;
        in_v_s = 1'b1;
        repeat (3) @(negedge clk);
        check(out_v_b == 1'b0, "R6 wide valid in reset", 128'(out_v_b), 128'd0);
        check(out_d_b == '0, "R6 wide data in reset", 128'(out_d_b), 128'd0);
        check(out_v_s == 1'b0, "R6 small valid in reset", 128'(out_v_s), 128'd0);
        check(out_d_s == '0, "R6 small data in reset", 128'(out_d_s), 128'd0);
        in_v_b = 1'b0;
        in_v_s = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_v_b == 1'b0 && out_d_b == '0, "R6 wide after release",
              {out_v_b, 63'd0, out_d_b}, 128'd0);

        // R7: boundary operands around q, 2q and 2^64.
        send_b(128'd0, "R7 zero");
        send_b(BQ - 1, "R7 q-1");
        send_b(BQ, "R7 q");
        send_b(BQ + 1, "R7 q+1");
        send_b(2 * BQ - 1, "R7 2q-1");
        send_b(2 * BQ, "R7 2q");
        send_b((128'd1 << 64) - 1, "R7 2^64-1");
        send_b(128'd1 << 64, "R7 2^64");
        send_b({128{1'b1}}, "R7 all ones");
        send_b(128'd1 << 127, "R7 top bit");
        send_b((BQ - 1) * (BQ - 1), "R8 (q-1)^2");
        send_b(BQ * 128'(64'hFFFF_FFFF), "R7 multiple of q");
        idle_b(8);

        // R1/R4: back-to-back random wide operands.
        for (int k = 0; k < 2000; k++) send_b(rnd128(), "R1 random wide");
        // R8: products of two residues, back to back.
        for (int k = 0; k < 1000; k++) begin
            a = rnd_res();
            b = rnd_res();
            send_b(128'(a) * 128'(b), "R8 residue product");
        end
        // R5: isolated operands separated by junk idle cycles.
        for (int k = 0; k < 60; k++) begin
            send_b(rnd128(), "R5 isolated operand");
            idle_b(7);
        end

        // R1: exhaustive small-input sweep.
        for (int x = 0; x < 4096; x++) send_s(12'(x), "R1 small exhaustive");
        // R8: every product of two small residues.
        for (int i = 0; i < SQ; i++) begin
            for (int j = 0; j < SQ; j++) send_s(12'(i * j), "R8 small product");
        end
        @(negedge clk);
        in_v_s = 1'b0;
        in_d_s = 12'hABC;

        repeat (12) @(negedge clk);
        check(exp_b_q.size() == 0, "R4 wide results missing", 128'(exp_b_q.size()), 128'd0);
        check(exp_s_q.size() == 0, "R4 small results missing", 128'(exp_s_q.size()), 128'd0);
        finish_run();
    end
endmodule